// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers a vector of level-sensitive interrupt requests and presents them to a processor as two outputs: a normal-priority request line and a fast request line. Every source is routed to both outputs, each through its own enable mask. Software changes a mask only through a pair of word addresses, one that sets bits and one that clears them. Because no write ever replaces a whole mask, two software agents can each own a subset of bits without a read-modify-write race.

The raw status register follows the source pins with one register of delay. Source 0 also carries a software-owned flag, so software can raise an interrupt on line 0 by writing a one and drop it by writing to a second address. Both outputs are registered. Each one goes high when the raw status ANDed with its mask is nonzero. Reads are combinational from the addressed register.

Top module: `dual_lvl_intc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both enable masks, the software flag and both outputs are zero.
- R2: Bit n of the raw status (read at word offset 1 or 9) equals the level of source n sampled at the previous rising clock edge, for every n ≥ 1.
- R3: A write to word offset 2 ORs the write data into the normal enable mask. The mask is read back at offset 2.
- R4: A write to word offset 3 clears the normal enable mask bits that are one in the write data and leaves the others unchanged.
- R5: A write to word offset 10 ORs the data into the fast enable mask, and a write to word offset 11 clears the selected bits. The mask is read back at offset 10.
- R6: Word offset 0 reads raw status AND normal mask. Word offset 8 reads raw status AND fast mask.
- R7: A write to word offset 4 with data bit 0 set sets the software flag, and a write to offset 5 with data bit 0 set clears it. A write with bit 0 clear changes nothing. Offset 4 reads raw status bit 0 in bit 0 and zero in all other bits.
- R8: Raw status bit 0 is the OR of source 0 and the software flag.
- R9: The normal output is high exactly when raw status AND normal mask is nonzero, and the fast output likewise with the fast mask. Both are registered, so they change in the same cycle as the raw status or mask that causes them.
- R10: Reads of offsets 3, 5 and 11, and of every unmapped offset (6, 7, 12 to 15), return zero.
- R11: Writes to offsets 0, 1, 8, 9 and to unmapped offsets change neither mask nor the software flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_src | input | NUM_SRC | Level-sensitive interrupt sources |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_addr | input | ADDR_W | Word offset of the access |
| reg_wdata | input | NUM_SRC | Write data |
| reg_rdata | output | NUM_SRC | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The bench looks hardest at the set and clear semantics. A design that wrote a mask instead of ORing into it would lose bits enabled earlier, and one that cleared at the wrong address would leave a stale enable that holds an output high. It checks that line 0 stays high when either the pin or the software flag asserts it, which a design that muxed the two would get wrong. It checks that a write with data bit 0 clear leaves the flag alone, and that writes to status offsets do not leak into a mask. It also compares the outputs in the very cycle a source or mask changes, so an extra pipeline stage shows up as a one-cycle mismatch.

// File: rtl/intc_pkg.sv
package intc_pkg;
  // Word offsets; the two targets share a layout shifted by 8.
  localparam int unsigned OFF_STAT    = 0;
  localparam int unsigned OFF_RAW     = 1;
  localparam int unsigned OFF_EN_SET  = 2;
  localparam int unsigned OFF_EN_CLR  = 3;
  localparam int unsigned OFF_SW_SET  = 4;
  localparam int unsigned OFF_SW_CLR  = 5;
  localparam int unsigned TGT_STRIDE  = 8;
  localparam int unsigned NUM_TGT     = 2;  // 0: normal, 1: fast

  function automatic int unsigned tgt_off(input int unsigned tgt, input int unsigned off);
    return tgt * TGT_STRIDE + off;
  endfunction
endpackage

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_d,
  output logic [W-1:0] mask_q
);
  always_comb begin
    mask_d = mask_q;
    if (set_en) mask_d = mask_q | wdata;
    else if (clr_en) mask_d = mask_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '0;
    else if (set_en || clr_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/intc_raw_capture.sv
module intc_raw_capture #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         sw_set,
  input  logic         sw_clr,
  output logic [W-1:0] raw_d,
  output logic [W-1:0] raw_q
);
  logic sw_q;
  logic sw_d;

  always_comb begin
    sw_d = sw_q;
    if (sw_set) sw_d = 1'b1;
    else if (sw_clr) sw_d = 1'b0;
    raw_d = src | {{(W-1){1'b0}}, sw_d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q  <= 1'b0;
      raw_q <= '0;
    end else begin
      if (sw_set || sw_clr) sw_q <= sw_d;
      raw_q <= raw_d;
    end
  end
endmodule

// File: rtl/intc_out_stage.sv
module intc_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_d,
  input  logic [W-1:0] mask_d,
  output logic         line_q
);
  logic line_d;

  always_comb line_d = |(raw_d & mask_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_q <= 1'b0;
    else line_q <= line_d;
  end
endmodule

// File: rtl/dual_lvl_intc.sv
module dual_lvl_intc
  import intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_src,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [NUM_SRC-1:0] reg_wdata,
  output logic [NUM_SRC-1:0] reg_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  localparam int unsigned W = NUM_SRC;

  logic [W-1:0] raw_d, raw_q;
  logic [W-1:0] en_d [NUM_TGT];
  logic [W-1:0] en_q [NUM_TGT];
  logic [NUM_TGT-1:0] line_q;
  logic sw_set, sw_clr;

  always_comb begin
    sw_set = reg_wr && (reg_addr == ADDR_W'(OFF_SW_SET)) && reg_wdata[0];
    sw_clr = reg_wr && (reg_addr == ADDR_W'(OFF_SW_CLR)) && reg_wdata[0];
  end

  intc_raw_capture #(.W(W)) u_raw (
    .clk(clk), .rst_n(rst_n), .src(irq_src),
    .sw_set(sw_set), .sw_clr(sw_clr),
    .raw_d(raw_d), .raw_q(raw_q)
  );

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    logic set_en, clr_en;
    always_comb begin
      set_en = reg_wr && (reg_addr == ADDR_W'(tgt_off(t, OFF_EN_SET)));
      clr_en = reg_wr && (reg_addr == ADDR_W'(tgt_off(t, OFF_EN_CLR)));
    end

    intc_mask_reg #(.W(W)) u_mask (
      .clk(clk), .rst_n(rst_n), .set_en(set_en), .clr_en(clr_en),
      .wdata(reg_wdata), .mask_d(en_d[t]), .mask_q(en_q[t])
    );

    intc_out_stage #(.W(W)) u_out (
      .clk(clk), .rst_n(rst_n), .raw_d(raw_d), .mask_d(en_d[t]),
      .line_q(line_q[t])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (reg_addr == ADDR_W'(tgt_off(t, OFF_STAT)))   reg_rdata = raw_q & en_q[t];
      if (reg_addr == ADDR_W'(tgt_off(t, OFF_RAW)))    reg_rdata = raw_q;
      if (reg_addr == ADDR_W'(tgt_off(t, OFF_EN_SET))) reg_rdata = en_q[t];
    end
    if (reg_addr == ADDR_W'(OFF_SW_SET)) reg_rdata = {{(W-1){1'b0}}, raw_q[0]};
  end

  assign irq_o = line_q[0];
  assign fiq_o = line_q[1];
endmodule

// File: rtl/dual_lvl_intc_chk.sv
module dual_lvl_intc_chk #(
  parameter int unsigned W = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [W-1:0]      irq_src,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [W-1:0]      reg_wdata,
  input logic [W-1:0]      raw_q,
  input logic [W-1:0]      irq_en,
  input logic [W-1:0]      fiq_en,
  input logic              irq_o,
  input logic              fiq_o
);
  a_r3_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> ((irq_en & $past(reg_wdata)) == $past(reg_wdata)));
  a_r4_irq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(3)) |=> ((irq_en & $past(reg_wdata)) == '0));
  a_r5_fiq_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(11)) |=> ((fiq_en & $past(reg_wdata)) == '0));
  a_r11_ro_write: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && (reg_addr == ADDR_W'(0) || reg_addr == ADDR_W'(1) ||
                reg_addr == ADDR_W'(8) || reg_addr == ADDR_W'(9)))
    |=> ($stable(irq_en) && $stable(fiq_en)));
  a_r2_raw_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (raw_q[W-1:1] == $past(irq_src[W-1:1])));
  a_r9_irq_line: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == |(raw_q & irq_en));
  a_r9_fiq_line: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o == |(raw_q & fiq_en));
endmodule

bind dual_lvl_intc dual_lvl_intc_chk #(.W(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .raw_q(raw_q),
  .irq_en(en_q[0]), .fiq_en(en_q[1]), .irq_o(irq_o), .fiq_o(fiq_o)
);

// File: tb/tb_dual_lvl_intc.sv
`timescale 1ns/100ps
module tb_dual_lvl_intc;
  localparam int W = 32;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] irq_src = '0;
  logic reg_wr = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic irq_o, fiq_o;

  int n_chk = 0;
  int n_err = 0;

  // bench model
  logic [W-1:0] m_ie = '0, m_fe = '0, m_raw = '0;
  logic m_sw = 1'b0;

  always #4 clk = ~clk;

  dual_lvl_intc #(.NUM_SRC(W), .ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o), .fiq_o(fiq_o)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_read(input int a);
    case (a)
      0: return m_raw & m_ie;
      1, 9: return m_raw;
      2: return m_ie;
      4: return {{(W-1){1'b0}}, m_raw[0]};
      8: return m_raw & m_fe;
      10: return m_fe;
      default: return '0;
    endcase
  endfunction

  task automatic rd(input string req, input int a);
    reg_addr = AW'(a);
    #0.1;
    chk(req, reg_rdata, exp_read(a));
  endtask

  // one cycle: drive at negedge, model updates at posedge, check at next negedge
  task automatic step(input logic [W-1:0] src, input logic we, input int a, input logic [W-1:0] d);
    @(negedge clk);
    irq_src = src; reg_wr = we; reg_addr = AW'(a); reg_wdata = d;
    @(posedge clk);
    if (we) begin
      case (a)
        2: m_ie |= d;
        3: m_ie &= ~d;
        10: m_fe |= d;
        11: m_fe &= ~d;
        4: if (d[0]) m_sw = 1'b1;
        5: if (d[0]) m_sw = 1'b0;
        default: ;
      endcase
    end
    m_raw = src | {{(W-1){1'b0}}, m_sw};
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R9 irq", {31'b0, irq_o}, {31'b0, |(m_raw & m_ie)});
    chk("R9 fiq", {31'b0, fiq_o}, {31'b0, |(m_raw & m_fe)});
    rd("R2 raw", 1);
    rd("R2 raw alias", 9);
    rd("R3 irq mask", 2);
    rd("R5 fiq mask", 10);
    rd("R6 irq status", 0);
    rd("R6 fiq status", 8);
    rd("R7 R8 line0", 4);
    rd("R10 zero read", 3);
    rd("R10 zero read", 5);
    rd("R10 zero read", 11);
    rd("R10 unmapped", 6 + int'($urandom_range(0, 1)) * 7);
  endtask

  initial begin : watchdog
    #1000000;
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h1c3a5));
    irq_src = 32'hffff_ffff;
    #20;
    chk("R1 irq in reset", {31'b0, irq_o}, '0);
    chk("R1 fiq in reset", {31'b0, fiq_o}, '0);
    reg_addr = 2; #0.1; chk("R1 irq mask reset", reg_rdata, '0);
    reg_addr = 10; #0.1; chk("R1 fiq mask reset", reg_rdata, '0);
    @(negedge clk); rst_n = 1'b1; irq_src = '0;
    @(negedge clk);
    chk("R1 irq after reset", {31'b0, irq_o}, '0);

    // directed: R3 OR semantics, R4 clear
    step(32'h0000_0010, 1, 2, 32'h0000_00f0);
    step(32'h0000_0010, 1, 2, 32'h0000_0f00);
    step(32'h0000_0010, 1, 3, 32'h0000_0010);   // R4 drops irq
    step(32'h0000_0100, 1, 10, 32'h0000_0100);  // R5 fast
    step(32'h0000_0100, 1, 11, 32'hffff_ffff);  // R5 clear all
    // R7 / R8 software flag on line 0
    step('0, 1, 2, 32'h1);
    step('0, 1, 4, 32'h2);                      // bit0 clear: no effect
    step('0, 1, 4, 32'h1);                      // sets
    step(32'h1, 1, 5, 32'h1);                   // flag cleared, pin holds line 0
    step('0, 0, 0, '0);
    step(32'h1, 1, 4, 32'h1);
    step('0, 1, 5, 32'hffff_fffe);              // bit0 clear: flag stays
    step('0, 1, 5, 32'h1);
    // R11 writes to read-only offsets
    step(32'h8000_0000, 1, 0, 32'hffff_ffff);
    step(32'h8000_0000, 1, 1, 32'hffff_ffff);
    step(32'h8000_0000, 1, 8, 32'hffff_ffff);
    step(32'h8000_0000, 1, 9, 32'hffff_ffff);
    step(32'h8000_0000, 1, 14, 32'hffff_ffff);

    // random mix
    for (int i = 0; i < 400; i++) begin
      int a;
      logic [W-1:0] s, d;
      a = int'($urandom_range(0, 15));
      s = $urandom() & $urandom();
      d = $urandom();
      if ($urandom_range(0, 3) == 0) d = d & $urandom() & $urandom();
      step(s, 1'($urandom_range(0, 3) != 0), a, d);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule